// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Converter

This block turns a signed fixed-point real number into a 32-bit single-precision floating-point word. The operand arrives as a sign flag and a magnitude split into two fields: an unsigned integer part (16 bits by default) and an unsigned fraction part (24 bits by default), with the binary point between them. The converter finds the most significant set bit of the joined magnitude and normalises the value to the form 1.f times 2^e. It then packs the sign, the exponent with a bias of 127, and the 23 fraction bits that follow the hidden one. Bits below those 23 are discarded, so the result is truncated toward zero.

Operands enter through a valid/ready handshake. The result sits in an output register with its own valid/ready pair. A two-state controller tracks whether that register holds an unread result. When the register is full and the consumer is stalled, the converter stops accepting input. When the consumer takes the held word in the same cycle that a new operand arrives, the new result replaces it with no lost cycle.

States: `ST_EMPTY` means no result is held, and `ST_FULL` means a result is waiting. Transitions:
- ACCEPT: `ST_EMPTY` to `ST_FULL` when an operand is accepted.
- REFILL: `ST_FULL` to `ST_FULL` when the held word is taken and a new operand is accepted in the same cycle.
- STALL: `ST_FULL` to `ST_FULL` while `out_ready` is low.
- DRAIN: `ST_FULL` to `ST_EMPTY` when the word is taken and no operand arrives.
- IDLE: `ST_EMPTY` to `ST_EMPTY` when nothing arrives.

Top module: `fx2sp_conv`

## Requirements
- R1: Bit 31 of `out_word` equals the `in_sign` of the accepted operand (0 for positive, 1 for negative).
- R2: For a nonzero magnitude, let p be the bit index of the leading one in {`in_int`,`in_frac`}, where bit 0 is the fraction LSB. Bits 30:23 then hold p - 24 + 127, which lies in the range 103 to 142.
- R3: Bits 22:0 hold the 23 magnitude bits directly below the leading one, most significant first. When fewer than 23 bits exist below it, the remaining low bits are zero. Lower bits are dropped without rounding.
- R4: An all-zero magnitude gives bits 30:0 all zero, with the sign bit still taken from `in_sign`.
- R5: When `in_int` is zero, the exponent comes from the fraction field alone, so bits 30:23 lie between 103 and 126.
- R6: An operand accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `out_word` with `out_valid` high right after that same edge. When `out_valid` and `out_ready` are high and no operand is accepted, `out_valid` falls after the edge.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_word` and `out_valid` hold their values.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: An operand offered while `in_ready` is low is ignored: `out_word` keeps the earlier result.
- R10: An integer part of 2815 with fraction 0x8CCCCC (about .55) gives an exponent field of 138 and mantissa bits 22:12 equal to 01011111111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Converter can take an operand this cycle |
| in_sign | input | 1 | Sign of the operand, 1 means negative |
| in_int | input | 16 | Unsigned integer part |
| in_frac | input | 24 | Unsigned fraction part |
| out_valid | output | 1 | `out_word` holds an unread result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Packed single-precision result |

## Verification
Two paths are the hardest to reach from the ports. The first is the REFILL transition under back-pressure: an operand must be offered while the held word is stalled, and then `out_ready` must rise while that operand is still offered. The bench drives this sequence in fixed steps and checks that the stalled word survives before the replacement lands. The second is the group of fraction-only exponents near the bottom of the range, which uniform random operands almost never produce. To reach them, random stimulus zeroes the integer part and shifts the fraction right by a random amount. Directed cases pin the single-LSB, all-ones and zero magnitudes.

// File: rtl/fx2sp_pkg.sv
package fx2sp_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } fx2sp_state_t;

    localparam int SP_EXP_W  = 8;
    localparam int SP_MANT_W = 23;
    localparam int SP_BIAS   = 127;

endpackage

// File: rtl/fx2sp_lead_one.sv
module fx2sp_lead_one #(
    parameter int W     = 40,
    parameter int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [POS_W-1:0] pos,
    output logic             found
);
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = POS_W'(i);
        end
        found = |vec;
    end
endmodule

// File: rtl/fx2sp_pack.sv
module fx2sp_pack #(
    parameter int W      = 40,
    parameter int FRAC_W = 24,
    parameter int EXP_W  = 8,
    parameter int MANT_W = 23,
    parameter int BIAS   = 127,
    parameter int POS_W  = $clog2(W)
) (
    input  logic                      sign,
    input  logic [W-1:0]              mag,
    input  logic [POS_W-1:0]          pos,
    input  logic                      found,
    output logic [EXP_W+MANT_W:0]     word
);
    localparam int OFFSET = BIAS - FRAC_W;
    localparam int TOP    = W - 1;

    logic [POS_W-1:0]  shamt;
    logic [W-1:0]      aligned;
    logic [EXP_W-1:0]  exp_f;
    logic [MANT_W-1:0] mant_f;

    always_comb begin
        shamt   = POS_W'(TOP) - pos;
        aligned = mag << shamt;
        if (found) begin
            exp_f  = EXP_W'(pos) + EXP_W'(OFFSET);
            mant_f = aligned[TOP-1 -: MANT_W];
        end else begin
            exp_f  = '0;
            mant_f = '0;
        end
        word = {sign, exp_f, mant_f};
    end
endmodule

// File: rtl/fx2sp_conv.sv
module fx2sp_conv #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 24,
    parameter int EXP_W  = fx2sp_pkg::SP_EXP_W,
    parameter int MANT_W = fx2sp_pkg::SP_MANT_W,
    parameter int BIAS   = fx2sp_pkg::SP_BIAS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   in_sign,
    input  logic [INT_W-1:0]       in_int,
    input  logic [FRAC_W-1:0]      in_frac,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [EXP_W+MANT_W:0]  out_word
);
    import fx2sp_pkg::*;

    localparam int W     = INT_W + FRAC_W;
    localparam int POS_W = $clog2(W);
    localparam int OUT_W = EXP_W + MANT_W + 1;

    fx2sp_state_t      state_q, state_d;
    logic [W-1:0]      mag;
    logic [POS_W-1:0]  lead_pos;
    logic              lead_found;
    logic [OUT_W-1:0]  word_c;
    logic              take;

    assign mag = {in_int, in_frac};

    fx2sp_lead_one #(.W(W), .POS_W(POS_W)) u_lead (
        .vec   (mag),
        .pos   (lead_pos),
        .found (lead_found)
    );

    fx2sp_pack #(
        .W(W), .FRAC_W(FRAC_W), .EXP_W(EXP_W),
        .MANT_W(MANT_W), .BIAS(BIAS), .POS_W(POS_W)
    ) u_pack (
        .sign  (in_sign),
        .mag   (mag),
        .pos   (lead_pos),
        .found (lead_found),
        .word  (word_c)
    );

    // outputs and next state
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) state_d = ST_FULL;          // ACCEPT
            end
            ST_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                if (out_ready && !in_valid) state_d = ST_EMPTY; // DRAIN
            end
            default: state_d = ST_EMPTY;
        endcase
        take = in_valid && in_ready;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    out_word <= '0;
        else if (take) out_word <= word_c;
    end
endmodule

// File: rtl/fx2sp_conv_chk.sv
module fx2sp_conv_chk #(
    parameter int OUT_W  = 32,
    parameter int MANT_W = 23,
    parameter int EXP_W  = 8,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 24,
    parameter int BIAS   = 127
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_word
);
    localparam int EXP_LO = BIAS - FRAC_W;
    localparam int EXP_HI = BIAS + INT_W - 1;

    p_stall_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    p_zero_mant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[OUT_W-2 -: EXP_W] == '0) |-> (out_word[MANT_W-1:0] == '0));

    p_exp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[OUT_W-2 -: EXP_W] != '0) |->
        (int'(out_word[OUT_W-2 -: EXP_W]) >= EXP_LO && int'(out_word[OUT_W-2 -: EXP_W]) <= EXP_HI));

    p_idle_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
endmodule

bind fx2sp_conv fx2sp_conv_chk #(
    .OUT_W(OUT_W), .MANT_W(MANT_W), .EXP_W(EXP_W),
    .INT_W(INT_W), .FRAC_W(FRAC_W), .BIAS(BIAS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
);

// File: tb/test_fx2sp_conv.sv
module test_fx2sp_conv;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sign = 1'b0;
    logic [15:0] in_int = '0;
    logic [23:0] in_frac = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fx2sp_conv i_fx2sp_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sign(in_sign), .in_int(in_int), .in_frac(in_frac),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
    );

    function automatic logic [31:0] ref_word(input logic s, input logic [15:0] ip, input logic [23:0] fp);
        logic [39:0] m;
        int          p;
        logic [22:0] mt;
        m  = {ip, fp};
        p  = -1;
        mt = '0;
        for (int i = 39; i >= 0; i--) begin
            if (p < 0 && m[i]) p = i;
        end
        if (p < 0) return {s, 31'd0};
        for (int k = 0; k < 23; k++) begin
            if (p - 1 - k >= 0) mt[22-k] = m[p-1-k];
        end
        return {s, 8'(p - 24 + 127), mt};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic convert(input string req, input logic s, input logic [15:0] ip, input logic [23:0] fp);
        @(negedge clk);
        in_valid = 1'b1; in_sign = s; in_int = ip; in_frac = fp;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check(req, out_word, ref_word(s, ip, fp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 out_valid", {31'd0, out_valid}, 32'd0);
        check("R8 in_ready", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;

        // R10 worked example
        convert("R10", 1'b0, 16'd2815, 24'h8CCCCC);
        check("R10 exp", {24'd0, out_word[30:23]}, 32'd138);
        check("R10 mant prefix", {21'd0, out_word[22:12]}, {21'd0, 11'b01011111111});
        // R4 zero magnitude, both signs
        convert("R4 +0", 1'b0, 16'd0, 24'd0);
        convert("R4 -0", 1'b1, 16'd0, 24'd0);
        check("R4 -0 word", out_word, 32'h8000_0000);
        // R2 largest magnitude
        convert("R2 max", 1'b1, 16'hFFFF, 24'hFFFFFF);
        check("R2 max exp", {24'd0, out_word[30:23]}, 32'd142);
        // R5 smallest fraction, R3 zero fill
        convert("R5 lsb", 1'b0, 16'd0, 24'd1);
        check("R5 lsb word", out_word, {1'b0, 8'd103, 23'd0});
        convert("R3 one", 1'b0, 16'd1, 24'd0);
        check("R3 one word", out_word, 32'h3F80_0000);
        convert("R5 half", 1'b1, 16'd0, 24'h800000);
        check("R1 half word", out_word, 32'hBF00_0000);
        // R3 truncation: bits below 23 dropped
        convert("R3 trunc", 1'b0, 16'h8000, 24'hFFFFFF);

        // R1/R2/R3/R5 random
        for (int n = 0; n < 300; n++) begin
            logic        s;
            logic [15:0] ip;
            logic [23:0] fp;
            s  = 1'($urandom % 2);
            ip = 16'($urandom);
            fp = 24'($urandom);
            if (n % 3 == 0) begin
                ip = '0;
                fp = fp >> ($urandom % 24);
            end else if (n % 3 == 1) begin
                ip = ip >> ($urandom % 16);
            end
            convert("R1R2R3 random", s, ip, fp);
        end

        // R7/R9 back-pressure, then REFILL and DRAIN (R6)
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_sign = 1'b0; in_int = 16'd5; in_frac = 24'd0;
        @(negedge clk);
        held = out_word;
        check("R6 stalled load", held, ref_word(1'b0, 16'd5, 24'd0));
        check("R7 in_ready low", {31'd0, in_ready}, 32'd0);
        in_int = 16'd9; in_sign = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 ignored while stalled", out_word, held);
        check("R7 still valid", {31'd0, out_valid}, 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 refill", out_word, ref_word(1'b1, 16'd9, 24'd0));
        check("R6 refill valid", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        check("R6 drain", {31'd0, out_valid}, 32'd0);
        check("R8 ready after drain", {31'd0, in_ready}, 32'd1);

        finish_run();
    end
endmodule